// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the 16-bit status and control word of a single root-hub port of a USB 1.1 host controller. Software reads and writes the word. Hardware events also update it: device attach (with a low-speed flag), device detach and remote wakeup. The word mixes three kinds of bit under fixed masks: bits that only hardware can change, bits that software owns, and change flags that software clears by writing a one.

The block produces three strobes, each one clock wide:

- A bus-reset pulse to the attached device. It fires only when software moves the port-reset bit from clear to set.
- A resume request to the controller. It fires when a suspended port sees a remote wakeup.
- An interrupt-check strobe. It tells the controller to re-evaluate its interrupt line after a port event.

A read port with an index selector returns this port's word when the index matches the parameter `PORT_SEL`. Any other index returns a fixed pattern that means "disabled port". A synchronous controller-reset input clears the word. It then restores the connect and low-speed bits for a device that is still present.

Top module: `hub_port_reg`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the word is 0x0000 and all three strobes are low.
- R2: A software write keeps the current value of every bit in mask 0x01BB (bits 0,1,3,4,5,7,8), and every other bit takes the written value.
- R3: After the merge of R2, a written 1 in bit 1 (connect change) or bit 3 (enable change) clears that bit. A written 0 leaves it unchanged.
- R4: A write with bit 9 (port reset) set, while bit 9 of the word is clear, gives `bus_reset_o` high for exactly one cycle. A write with bit 9 set while it is already set gives no pulse.
- R5: While no device is attached, a software write changes nothing and gives no bus-reset pulse.
- R6: Attach sets bit 0 (connect) and bit 1 (connect change). It sets bit 8 for a low-speed device and clears bit 8 for a full-speed one.
- R7: Detach clears bit 0 and sets bit 1 if bit 0 was set. It clears bit 2 (enable) and sets bit 3 if bit 2 was set. Detach also marks the port as having no device.
- R8: A wakeup while bit 12 (suspend) is set and bit 6 (resume detect) is clear sets bit 6 and pulses `resume_req_o` for one cycle. In any other state a wakeup leaves the word unchanged.
- R9: `rd_data_o` equals the word when `rd_sel_i == PORT_SEL`, and 0xFF7F for any other index.
- R10: A controller reset sets the word to 0x0000. If a device is still attached, bit 0 is then set, together with bit 8 when that device is low-speed. Controller reset takes priority over events and writes in the same cycle.
- R11: An attach, detach or wakeup in the same cycle as a software write takes priority, and that write is dropped entirely, including any bus-reset pulse.
- R12: `irq_check_o` pulses for one cycle after every attach, every detach, and every wakeup that sets bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_reset_i | input | 1 | Synchronous controller reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 16 | Software write value |
| rd_sel_i | input | SEL_W | Port index being read |
| rd_data_o | output | 16 | Read data |
| attach_i | input | 1 | Device attach event |
| low_speed_i | input | 1 | Attached device is low-speed (valid with attach) |
| detach_i | input | 1 | Device detach event |
| wakeup_i | input | 1 | Remote wakeup event |
| bus_reset_o | output | 1 | One-cycle reset pulse to the device |
| resume_req_o | output | 1 | One-cycle resume request to the controller |
| irq_check_o | output | 1 | One-cycle interrupt re-evaluation strobe |

## Verification
The word and all three strobes are registered. The effect of a write, event or controller reset therefore becomes visible right after the clock edge that samples the stimulus. Each strobe falls again after the following edge. The read path is combinational, so a change of `rd_sel_i` is due in the same cycle. The bench drives inputs one time unit after a rising edge and samples one unit after the next rising edge. It then advances one more edge to confirm that each strobe has dropped. Expected words come from an arithmetic model of the mask rules, applied to sweeps of single-bit and mixed write values.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;
  localparam int REG_W = 16;

  localparam int B_CONN     = 0;
  localparam int B_CONN_CHG = 1;
  localparam int B_EN       = 2;
  localparam int B_EN_CHG   = 3;
  localparam int B_RESUME   = 6;
  localparam int B_LOWSPD   = 8;
  localparam int B_RST      = 9;
  localparam int B_SUSP     = 12;

  localparam logic [REG_W-1:0] KEEP_MASK  = 16'h01BB;
  localparam logic [REG_W-1:0] W1C_MASK   = 16'h000A;
  localparam logic [REG_W-1:0] ABSENT_VAL = 16'hFF7F;
endpackage

// File: rtl/hub_port_wr.sv
module hub_port_wr
  import hub_port_pkg::*;
(
  input  logic [REG_W-1:0] cur_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] nxt_o,
  output logic             rst_rise_o
);
  logic [REG_W-1:0] merged;

  always_comb begin
    merged     = (cur_i & KEEP_MASK) | (wdata_i & ~KEEP_MASK);
    nxt_o      = merged & ~(wdata_i & W1C_MASK);
    rst_rise_o = wdata_i[B_RST] & ~cur_i[B_RST];
  end
endmodule

// File: rtl/hub_port_evt.sv
module hub_port_evt
  import hub_port_pkg::*;
(
  input  logic [REG_W-1:0] cur_i,
  input  logic             attach_i,
  input  logic             low_speed_i,
  input  logic             detach_i,
  input  logic             wakeup_i,
  output logic [REG_W-1:0] nxt_o,
  output logic             hit_o,
  output logic             irq_o,
  output logic             resume_o
);
  always_comb begin
    nxt_o    = cur_i;
    hit_o    = 1'b0;
    irq_o    = 1'b0;
    resume_o = 1'b0;
    if (detach_i) begin
      hit_o = 1'b1;
      irq_o = 1'b1;
      if (cur_i[B_CONN]) begin
        nxt_o[B_CONN]     = 1'b0;
        nxt_o[B_CONN_CHG] = 1'b1;
      end
      if (cur_i[B_EN]) begin
        nxt_o[B_EN]     = 1'b0;
        nxt_o[B_EN_CHG] = 1'b1;
      end
    end else if (attach_i) begin
      hit_o             = 1'b1;
      irq_o             = 1'b1;
      nxt_o[B_CONN]     = 1'b1;
      nxt_o[B_CONN_CHG] = 1'b1;
      nxt_o[B_LOWSPD]   = low_speed_i;
    end else if (wakeup_i) begin
      hit_o = 1'b1;
      if (cur_i[B_SUSP] && !cur_i[B_RESUME]) begin
        nxt_o[B_RESUME] = 1'b1;
        resume_o        = 1'b1;
        irq_o           = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hub_port_reg.sv
module hub_port_reg
  import hub_port_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int PORT_SEL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_reset_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             attach_i,
  input  logic             low_speed_i,
  input  logic             detach_i,
  input  logic             wakeup_i,
  output logic             bus_reset_o,
  output logic             resume_req_o,
  output logic             irq_check_o
);
  localparam logic [SEL_W-1:0] SEL_MATCH = SEL_W'(PORT_SEL);

  logic [REG_W-1:0] status_q;
  logic             attached_q, ls_q;
  logic             bus_reset_q, resume_q, irq_q;

  logic [REG_W-1:0] wr_nxt, evt_nxt, creset_val;
  logic             wr_rise, evt_hit, evt_irq, evt_resume;

  hub_port_wr u_wr (
    .cur_i      (status_q),
    .wdata_i    (wr_data_i),
    .nxt_o      (wr_nxt),
    .rst_rise_o (wr_rise)
  );

  hub_port_evt u_evt (
    .cur_i       (status_q),
    .attach_i    (attach_i),
    .low_speed_i (low_speed_i),
    .detach_i    (detach_i),
    .wakeup_i    (wakeup_i),
    .nxt_o       (evt_nxt),
    .hit_o       (evt_hit),
    .irq_o       (evt_irq),
    .resume_o    (evt_resume)
  );

  always_comb begin
    creset_val           = '0;
    creset_val[B_CONN]   = attached_q;
    creset_val[B_LOWSPD] = attached_q & ls_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= '0;
      attached_q  <= 1'b0;
      ls_q        <= 1'b0;
      bus_reset_q <= 1'b0;
      resume_q    <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      bus_reset_q <= 1'b0;
      resume_q    <= 1'b0;
      irq_q       <= 1'b0;
      if (ctrl_reset_i) begin
        status_q <= creset_val;
      end else if (evt_hit) begin
        status_q <= evt_nxt;
        resume_q <= evt_resume;
        irq_q    <= evt_irq;
        if (detach_i) begin
          attached_q <= 1'b0;
        end else if (attach_i) begin
          attached_q <= 1'b1;
          ls_q       <= low_speed_i;
        end
      end else if (wr_en_i && attached_q) begin
        status_q    <= wr_nxt;
        bus_reset_q <= wr_rise;
      end
    end
  end

  assign rd_data_o    = (rd_sel_i == SEL_MATCH) ? status_q : ABSENT_VAL;
  assign bus_reset_o  = bus_reset_q;
  assign resume_req_o = resume_q;
  assign irq_check_o  = irq_q;
endmodule

// File: rtl/hub_port_reg_chk.sv
module hub_port_reg_chk
  import hub_port_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_reset_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             attach_i,
  input logic             detach_i,
  input logic             wakeup_i,
  input logic [REG_W-1:0] status_q,
  input logic             attached_q,
  input logic             bus_reset_o,
  input logic             resume_req_o,
  input logic             irq_check_o
);
  logic quiet;
  assign quiet = !ctrl_reset_i && !attach_i && !detach_i && !wakeup_i;

  assert_pulse_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |=> !bus_reset_o);

  assert_reset_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_o |-> $past(wr_en_i) && $past(wr_data_i[B_RST]) && status_q[B_RST]);

  assert_no_write_detached_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && !attached_q) |=> $stable(status_q) && !bus_reset_o);

  assert_attach_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (attach_i && !detach_i && !ctrl_reset_i) |=> status_q[B_CONN] && status_q[B_CONN_CHG]);

  assert_detach_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detach_i && !ctrl_reset_i) |=> !status_q[B_CONN] && !status_q[B_EN] && !attached_q);

  assert_resume_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_req_o |-> status_q[B_RESUME] && !$past(status_q[B_RESUME]));

  assert_event_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !quiet) |=> !bus_reset_o);

  assert_irq_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_check_o |-> $past(attach_i) || $past(detach_i) || $past(wakeup_i));
endmodule

bind hub_port_reg hub_port_reg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_reset_i (ctrl_reset_i),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .attach_i     (attach_i),
  .detach_i     (detach_i),
  .wakeup_i     (wakeup_i),
  .status_q     (status_q),
  .attached_q   (attached_q),
  .bus_reset_o  (bus_reset_o),
  .resume_req_o (resume_req_o),
  .irq_check_o  (irq_check_o)
);

// File: tb/hub_port_reg_test.sv
module hub_port_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_reset_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [SEL_W-1:0] rd_sel_i = '0;
  logic [15:0] rd_data_o;
  logic        attach_i = 1'b0, low_speed_i = 1'b0, detach_i = 1'b0, wakeup_i = 1'b0;
  logic        bus_reset_o, resume_req_o, irq_check_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q = '0;
  logic        done = 1'b0;

  hub_port_reg #(.SEL_W(SEL_W), .PORT_SEL(0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_reset_i(ctrl_reset_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .attach_i(attach_i), .low_speed_i(low_speed_i),
    .detach_i(detach_i), .wakeup_i(wakeup_i), .bus_reset_o(bus_reset_o),
    .resume_req_o(resume_req_o), .irq_check_o(irq_check_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // strobes due right after the sampling edge, gone after the next
  task automatic chk_strobes(input string tag, input logic br, input logic rr, input logic ic);
    chk({tag, " strobes"}, {13'd0, bus_reset_o, resume_req_o, irq_check_o}, {13'd0, br, rr, ic});
    tick();
    chk({tag, " strobes drop"}, {13'd0, bus_reset_o, resume_req_o, irq_check_o}, 16'd0);
  endtask

  task automatic sw_write(input logic [15:0] wd, input string tag);
    logic rise;
    rise = wd[9] & ~exp_q[9];
    exp_q = ((exp_q & 16'h01BB) | (wd & ~16'h01BB)) & ~(wd & 16'h000A);
    wr_en_i = 1'b1; wr_data_i = wd;
    tick();
    wr_en_i = 1'b0;
    chk(tag, rd_data_o, exp_q);
    chk_strobes(tag, rise, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    chk("R1 word", rd_data_o, 16'h0000);
    chk("R1 strobes", {13'd0, bus_reset_o, resume_req_o, irq_check_o}, 16'd0);
    rst_ni = 1'b1;
    tick();

    // R9 absent indices
    for (int s = 1; s < 4; s++) begin
      rd_sel_i = SEL_W'(s);
      #1 chk("R9 absent", rd_data_o, 16'hFF7F);
    end
    rd_sel_i = '0;
    #1 chk("R9 present", rd_data_o, 16'h0000);

    // R5 write with no device
    wr_en_i = 1'b1; wr_data_i = 16'hFFFF;
    tick();
    wr_en_i = 1'b0;
    chk("R5 word", rd_data_o, 16'h0000);
    chk_strobes("R5", 1'b0, 1'b0, 1'b0);

    // R6 low-speed attach
    attach_i = 1'b1; low_speed_i = 1'b1;
    tick();
    attach_i = 1'b0; low_speed_i = 1'b0;
    exp_q = 16'h0103;
    chk("R6 low-speed attach", rd_data_o, exp_q);
    chk_strobes("R12 attach", 1'b0, 1'b0, 1'b1);

    // R2 R3 R4 single-bit sweep, each bit set then cleared
    for (int b = 0; b < 16; b++) begin
      sw_write(16'(1) << b, $sformatf("R2/R3/R4 set bit %0d", b));
      sw_write(16'h0000, $sformatf("R2 clear after bit %0d", b));
    end
    // mixed patterns, R4 no pulse when reset already set
    sw_write(16'h0200, "R4 rise");
    sw_write(16'h0200, "R4 no re-rise");
    sw_write(16'hAAAA, "R2 pattern A");
    sw_write(16'h5555, "R2 pattern 5");
    sw_write(16'hFFFF, "R3 all ones");
    sw_write(16'h0000, "R2 all zeros");

    // R8 wakeup
    wakeup_i = 1'b1;
    tick();
    wakeup_i = 1'b0;
    chk("R8 wakeup not suspended", rd_data_o, exp_q);
    chk_strobes("R8 no resume", 1'b0, 1'b0, 1'b0);
    sw_write(16'h1004, "R8 suspend+enable");
    wakeup_i = 1'b1;
    tick();
    wakeup_i = 1'b0;
    exp_q[6] = 1'b1;
    chk("R8 resume detect", rd_data_o, exp_q);
    chk_strobes("R8/R12 resume", 1'b0, 1'b1, 1'b1);
    wakeup_i = 1'b1;
    tick();
    wakeup_i = 1'b0;
    chk("R8 second wakeup", rd_data_o, exp_q);
    chk_strobes("R8 second", 1'b0, 1'b0, 1'b0);

    // R11 full-speed attach beats simultaneous write
    sw_write(16'h0000, "R11 prep");
    attach_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'hFFFF;
    tick();
    attach_i = 1'b0; wr_en_i = 1'b0;
    exp_q = (exp_q | 16'h0003) & ~16'h0100;
    chk("R11 attach over write", rd_data_o, exp_q);
    chk_strobes("R11", 1'b0, 1'b0, 1'b1);

    // R10 controller reset, full-speed device present
    sw_write(16'h1204, "R10 prep");
    ctrl_reset_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'h0004;
    tick();
    ctrl_reset_i = 1'b0; wr_en_i = 1'b0;
    exp_q = 16'h0001;
    chk("R10 reset with full-speed", rd_data_o, exp_q);
    attach_i = 1'b1; low_speed_i = 1'b1;
    tick();
    attach_i = 1'b0; low_speed_i = 1'b0;
    ctrl_reset_i = 1'b1;
    tick();
    ctrl_reset_i = 1'b0;
    exp_q = 16'h0101;
    chk("R10 reset with low-speed", rd_data_o, exp_q);

    // R7 detach with enable set
    sw_write(16'h0004, "R7 enable");
    detach_i = 1'b1;
    tick();
    detach_i = 1'b0;
    exp_q = 16'h010A;
    chk("R7 detach", rd_data_o, exp_q);
    chk_strobes("R7/R12 detach", 1'b0, 1'b0, 1'b1);
    detach_i = 1'b1;
    tick();
    detach_i = 1'b0;
    chk("R7 second detach", rd_data_o, exp_q);
    wr_en_i = 1'b1; wr_data_i = 16'h020A;
    tick();
    wr_en_i = 1'b0;
    chk("R5 after detach", rd_data_o, exp_q);
    chk_strobes("R5 after detach", 1'b0, 1'b0, 1'b0);
    ctrl_reset_i = 1'b1;
    tick();
    ctrl_reset_i = 1'b0;
    chk("R10 reset detached", rd_data_o, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule